// File: doc/BRIEF.md
# 64-bit Single-Error ECC Syndrome Locator

This block examines a 64-bit data word, presented as an upper and a lower 32-bit half, together with the 8-bit check byte stored alongside it. It rebuilds the check byte from the data with a fixed parity matrix and XORs the result with the stored byte to form a syndrome. From the syndrome it decides whether the word is clean, whether one data bit is at fault, whether one check bit is at fault, or whether the damage is beyond single-bit repair. It then returns the repaired data and check byte.

The matrix is not a textbook Hamming layout. It is defined by eight pairs of 32-bit masks. Each data bit's syndrome column is read out of those masks, and the faulty bit is found by comparing the syndrome against all 64 columns in parallel. A result is loaded into the output registers on a strobe and is flagged valid in the following cycle. A scrubber or read-return path uses the block to log the fault and write back or forward the repaired word.

Top module: `ecc_syn_locator`

## Requirements
- R1: Check bit k (k = 0..7) is the XOR of `in_hi` bits selected by high mask k and `in_lo` bits selected by low mask k. The (high, low) masks for k = 0..7 are (F00FE11E, C33C0FF7), (00FF00FF, 00FFF0FF), (0F0F0F0F, 0F0FFF00), (11113333, 7777000F), (22224444, 8888222F), (44448888, FFFF4441), (8888FFFF, 11118882), (FFFF1111, 22221114). With a stored byte of zero, `syndrome` equals the recomputed check byte.
- R2: `syndrome` is the recomputed check byte XOR `in_chk`. A zero syndrome raises `no_err`, clears both index-valid flags and `uncorrectable`, and passes data and check byte through. Exactly one of `no_err`, `dbit_vld`, `cbit_vld` and `uncorrectable` is high with each result.
- R3: The column of data bit n holds, at syndrome position k, bit (n mod 32) of high mask k when n >= 32, or of low mask k otherwise. A nonzero syndrome equal to a column sets `dbit_vld` and reports the lowest such n on `dbit_idx`.
- R4: When `dbit_vld` is set, `{corr_hi, corr_lo}` is the input word with bit `dbit_idx` inverted and `corr_chk` equals `in_chk`.
- R5: A nonzero syndrome that matches no data column and has exactly one bit set raises `cbit_vld`, reports that bit position on `cbit_idx`, inverts that bit in `corr_chk`, and passes the data through.
- R6: A nonzero syndrome that matches no data column and has two or more bits set raises `uncorrectable`, clears both index-valid flags, and passes data and check byte through unchanged.
- R7: A result is loaded at the clock edge that samples `in_valid` high. `out_valid` is high for the cycle after each strobe and low otherwise, and all result outputs hold their values while no strobe arrives.
- R8: While `rst` is high, `out_valid` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: load a word for checking |
| in_hi | input | 32 | Data bits 63..32 |
| in_lo | input | 32 | Data bits 31..0 |
| in_chk | input | 8 | Stored check byte |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| syndrome | output | 8 | Recomputed check XOR stored check |
| no_err | output | 1 | Syndrome is zero |
| dbit_vld | output | 1 | A data bit was located |
| dbit_idx | output | 6 | Located data bit index |
| cbit_vld | output | 1 | A check bit was located |
| cbit_idx | output | 3 | Located check bit index |
| uncorrectable | output | 1 | Multi-bit error, nothing corrected |
| corr_hi | output | 32 | Corrected data bits 63..32 |
| corr_lo | output | 32 | Corrected data bits 31..0 |
| corr_chk | output | 8 | Corrected check byte |

## Verification
On every cycle, the assertions check that the four outcome flags are mutually exclusive, that `no_err` agrees with a zero syndrome, and that a located check bit is the single set syndrome bit. They also check that a located data bit changes exactly one bit of the word, that an uncorrectable result leaves the word untouched, and that `out_valid` follows the strobe by one cycle. Only the bench scenarios can show that the syndrome follows the specific mask matrix and that the reported index is the right column. They do this by sweeping every single data-bit and check-bit flip, adjacent double flips and clean words over several data patterns against an arithmetic model of the matrix.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;
  localparam int HALF_W = 32;
  localparam int DATA_W = 2 * HALF_W;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CHK_W);

  function automatic logic [HALF_W-1:0] mask_hi(input int k);
    case (k)
      0: mask_hi = 32'hF00FE11E;
      1: mask_hi = 32'h00FF00FF;
      2: mask_hi = 32'h0F0F0F0F;
      3: mask_hi = 32'h11113333;
      4: mask_hi = 32'h22224444;
      5: mask_hi = 32'h44448888;
      6: mask_hi = 32'h8888FFFF;
      default: mask_hi = 32'hFFFF1111;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] mask_lo(input int k);
    case (k)
      0: mask_lo = 32'hC33C0FF7;
      1: mask_lo = 32'h00FFF0FF;
      2: mask_lo = 32'h0F0FFF00;
      3: mask_lo = 32'h7777000F;
      4: mask_lo = 32'h8888222F;
      5: mask_lo = 32'hFFFF4441;
      6: mask_lo = 32'h11118882;
      default: mask_lo = 32'h22221114;
    endcase
  endfunction

  // Syndrome column produced by a flip of data bit n
  function automatic logic [CHK_W-1:0] data_col(input int n);
    logic [CHK_W-1:0] c;
    logic [HALF_W-1:0] m;
    for (int k = 0; k < CHK_W; k++) begin
      m    = (n >= HALF_W) ? mask_hi(k) : mask_lo(k);
      c[k] = m[n % HALF_W];
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
  import ecc_loc_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int CW = CHK_W
) (
  input  logic [HW-1:0] hi,
  input  logic [HW-1:0] lo,
  output logic [CW-1:0] chk
);
  for (genvar k = 0; k < CW; k++) begin : g_bit
    localparam logic [HW-1:0] MH = mask_hi(k);
    localparam logic [HW-1:0] ML = mask_lo(k);
    assign chk[k] = (^(hi & MH)) ^ (^(lo & ML));
  end
endmodule

// File: rtl/ecc_col_match.sv
module ecc_col_match
  import ecc_loc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  localparam int IW = $clog2(DW)
) (
  input  logic [CW-1:0] syn,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [DW-1:0] match;

  for (genvar n = 0; n < DW; n++) begin : g_col
    localparam logic [CW-1:0] COL = data_col(n);
    assign match[n] = (|syn) && (syn == COL);
  end

  assign hit = |match;

  // lowest matching column wins
  always_comb begin
    idx = '0;
    for (int n = DW - 1; n >= 0; n--) begin
      if (match[n]) idx = IW'(n);
    end
  end
endmodule

// File: rtl/ecc_chk_locate.sv
module ecc_chk_locate #(
  parameter int CW = 8,
  localparam int KW = $clog2(CW)
) (
  input  logic [CW-1:0] syn,
  output logic          single,
  output logic [KW-1:0] idx
);
  assign single = (|syn) && ((syn & (syn - CW'(1))) == '0);

  always_comb begin
    idx = '0;
    for (int k = CW - 1; k >= 0; k--) begin
      if (syn[k]) idx = KW'(k);
    end
  end
endmodule

// File: rtl/ecc_syn_locator.sv
module ecc_syn_locator
  import ecc_loc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_hi,
  input  logic [31:0]       in_lo,
  input  logic [7:0]        in_chk,
  output logic              out_valid,
  output logic [7:0]        syndrome,
  output logic              no_err,
  output logic              dbit_vld,
  output logic [5:0]        dbit_idx,
  output logic              cbit_vld,
  output logic [2:0]        cbit_idx,
  output logic              uncorrectable,
  output logic [31:0]       corr_hi,
  output logic [31:0]       corr_lo,
  output logic [7:0]        corr_chk
);
  logic [CHK_W-1:0]  chk_new, syn_c;
  logic              d_hit, c_single;
  logic [IDX_W-1:0]  d_idx;
  logic [CIDX_W-1:0] c_idx;
  logic              nz, dv_c, cv_c, ue_c;
  logic [DATA_W-1:0] dflip, word_c;
  logic [CHK_W-1:0]  cflip;

  ecc_chk_gen #(.HW(HALF_W), .CW(CHK_W)) u_gen (
    .hi(in_hi), .lo(in_lo), .chk(chk_new)
  );

  assign syn_c = chk_new ^ in_chk;

  ecc_col_match #(.DW(DATA_W), .CW(CHK_W)) u_col (
    .syn(syn_c), .hit(d_hit), .idx(d_idx)
  );

  ecc_chk_locate #(.CW(CHK_W)) u_cloc (
    .syn(syn_c), .single(c_single), .idx(c_idx)
  );

  always_comb begin
    nz     = |syn_c;
    dv_c   = nz && d_hit;
    cv_c   = nz && !d_hit && c_single;
    ue_c   = nz && !d_hit && !c_single;
    dflip  = dv_c ? (DATA_W'(1) << d_idx) : '0;
    cflip  = cv_c ? (CHK_W'(1) << c_idx) : '0;
    word_c = {in_hi, in_lo} ^ dflip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      syndrome      <= '0;
      no_err        <= 1'b0;
      dbit_vld      <= 1'b0;
      dbit_idx      <= '0;
      cbit_vld      <= 1'b0;
      cbit_idx      <= '0;
      uncorrectable <= 1'b0;
      corr_hi       <= '0;
      corr_lo       <= '0;
      corr_chk      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        syndrome      <= syn_c;
        no_err        <= !nz;
        dbit_vld      <= dv_c;
        dbit_idx      <= dv_c ? d_idx : '0;
        cbit_vld      <= cv_c;
        cbit_idx      <= cv_c ? c_idx : '0;
        uncorrectable <= ue_c;
        corr_hi       <= word_c[DATA_W-1:HALF_W];
        corr_lo       <= word_c[HALF_W-1:0];
        corr_chk      <= in_chk ^ cflip;
      end
    end
  end
endmodule

// File: rtl/ecc_syn_locator_chk.sv
module ecc_syn_locator_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_hi,
  input logic [31:0] in_lo,
  input logic [7:0]  in_chk,
  input logic        out_valid,
  input logic [7:0]  syndrome,
  input logic        no_err,
  input logic        dbit_vld,
  input logic        cbit_vld,
  input logic [2:0]  cbit_idx,
  input logic        uncorrectable,
  input logic [31:0] corr_hi,
  input logic [31:0] corr_lo,
  input logic [7:0]  corr_chk
);
  // R2: one outcome per result
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({no_err, dbit_vld, cbit_vld, uncorrectable}) == 1);

  // R2: no_err tracks zero syndrome
  p_noerr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (no_err == (syndrome == 8'h00)));

  // R5: located check bit is the lone syndrome bit
  p_chk_single_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cbit_vld) |-> (syndrome == (8'h01 << cbit_idx)));

  // R4: data correction changes one bit
  p_data_flip_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!dbit_vld ||
      $countones({corr_hi, corr_lo} ^ $past({in_hi, in_lo})) == 1));

  // R6: uncorrectable passes through
  p_ue_pass_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!uncorrectable ||
      ({corr_hi, corr_lo, corr_chk} == $past({in_hi, in_lo, in_chk}))));

  // R7: valid follows strobe
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

bind ecc_syn_locator ecc_syn_locator_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_lo(in_lo),
  .in_chk(in_chk), .out_valid(out_valid), .syndrome(syndrome),
  .no_err(no_err), .dbit_vld(dbit_vld), .cbit_vld(cbit_vld),
  .cbit_idx(cbit_idx), .uncorrectable(uncorrectable), .corr_hi(corr_hi),
  .corr_lo(corr_lo), .corr_chk(corr_chk)
);

// File: tb/sim_ecc_syn_locator.sv
`timescale 1ns/1ps
module sim_ecc_syn_locator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_hi = '0, in_lo = '0;
  logic [7:0]  in_chk = '0;
  logic        out_valid, no_err, dbit_vld, cbit_vld, uncorrectable;
  logic [7:0]  syndrome, corr_chk;
  logic [5:0]  dbit_idx;
  logic [2:0]  cbit_idx;
  logic [31:0] corr_hi, corr_lo;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ecc_syn_locator u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_lo(in_lo),
    .in_chk(in_chk), .out_valid(out_valid), .syndrome(syndrome),
    .no_err(no_err), .dbit_vld(dbit_vld), .dbit_idx(dbit_idx),
    .cbit_vld(cbit_vld), .cbit_idx(cbit_idx), .uncorrectable(uncorrectable),
    .corr_hi(corr_hi), .corr_lo(corr_lo), .corr_chk(corr_chk)
  );

  localparam logic [31:0] MH [8] = '{32'hF00FE11E, 32'h00FF00FF, 32'h0F0F0F0F,
    32'h11113333, 32'h22224444, 32'h44448888, 32'h8888FFFF, 32'hFFFF1111};
  localparam logic [31:0] ML [8] = '{32'hC33C0FF7, 32'h00FFF0FF, 32'h0F0FFF00,
    32'h7777000F, 32'h8888222F, 32'hFFFF4441, 32'h11118882, 32'h22221114};

  function automatic logic [7:0] ref_chk(logic [31:0] h, logic [31:0] l);
    logic [7:0] c;
    for (int k = 0; k < 8; k++) c[k] = (^(h & MH[k])) ^ (^(l & ML[k]));
    return c;
  endfunction

  function automatic logic [7:0] ref_col(int n);
    logic [7:0] c;
    for (int k = 0; k < 8; k++)
      c[k] = (n >= 32) ? MH[k][n-32] : ML[k][n];
    return c;
  endfunction

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] h, logic [31:0] l, logic [7:0] c);
    logic [7:0]  s;
    int          hitn;
    logic        e_no, e_dv, e_cv, e_ue;
    logic [5:0]  e_di;
    logic [2:0]  e_ci;
    logic [63:0] w;
    logic [7:0]  e_cc;
    s = ref_chk(h, l) ^ c;
    hitn = -1;
    if (s != 0)
      for (int n = 63; n >= 0; n--) if (ref_col(n) == s) hitn = n;
    e_no = (s == 0);
    e_dv = (hitn >= 0);
    e_cv = !e_no && !e_dv && ($countones(s) == 1);
    e_ue = !e_no && !e_dv && !e_cv;
    e_di = e_dv ? 6'(hitn) : 6'd0;
    e_ci = 3'd0;
    if (e_cv) for (int k = 7; k >= 0; k--) if (s[k]) e_ci = 3'(k);
    w = {h, l};
    if (e_dv) w[hitn] = ~w[hitn];
    e_cc = c;
    if (e_cv) e_cc[e_ci] = ~e_cc[e_ci];
    @(negedge clk);
    in_hi = h; in_lo = l; in_chk = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 out_valid", 96'(out_valid), 96'(1'b1));
    check("R1/R2 syndrome and flags",
          96'({syndrome, no_err, dbit_vld, cbit_vld, uncorrectable}),
          96'({s, e_no, e_dv, e_cv, e_ue}));
    if (e_dv)
      check("R3/R4 data index and correction",
            {dbit_idx, corr_hi, corr_lo, corr_chk, 18'd0},
            {e_di, w, e_cc, 18'd0});
    else if (e_cv)
      check("R5 check index and correction",
            {cbit_idx, corr_hi, corr_lo, corr_chk, 21'd0},
            {e_ci, w, e_cc, 21'd0});
    else if (e_ue)
      check("R6 pass-through",
            {dbit_idx, cbit_idx, corr_hi, corr_lo, corr_chk, 15'd0},
            {6'd0, 3'd0, w, e_cc, 15'd0});
    else
      check("R2 clean pass-through",
            {dbit_idx, cbit_idx, corr_hi, corr_lo, corr_chk, 15'd0},
            {6'd0, 3'd0, w, e_cc, 15'd0});
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [63:0] pats [5];
    logic [31:0] hh, ll;
    logic [7:0]  cc;
    logic [95:0] held;
    pats = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_C3C3_3C3C,
             64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0BAD_F00D};
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset",
          {out_valid, syndrome, no_err, dbit_vld, dbit_idx, cbit_vld, cbit_idx,
           uncorrectable, corr_hi, corr_lo, corr_chk},
          96'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 idle out_valid", 96'(out_valid), 96'd0);

    for (int p = 0; p < 5; p++) begin
      hh = pats[p][63:32];
      ll = pats[p][31:0];
      cc = ref_chk(hh, ll);
      run(hh, ll, 8'h00);            // R1 raw check byte
      run(hh, ll, cc);               // R2 clean word
      for (int n = 0; n < 64; n++) begin
        logic [63:0] w;
        w = pats[p];
        w[n] = ~w[n];
        run(w[63:32], w[31:0], cc);  // R3/R4 single data flips
      end
      for (int k = 0; k < 8; k++)
        run(hh, ll, cc ^ (8'h01 << k)); // R5 single check flips
      for (int n = 0; n < 64; n++) begin
        logic [63:0] w;
        w = pats[p];
        w[n] = ~w[n];
        w[(n + 1) % 64] = ~w[(n + 1) % 64];
        run(w[63:32], w[31:0], cc);  // R6 double data flips
      end
      for (int k = 0; k < 7; k++)
        run(hh, ll, cc ^ (8'h03 << k)); // R6 double check flips
    end

    // R7: results hold with no strobe
    run(32'h1234_5678, 32'h9ABC_DEF0, 8'h5A);
    held = {syndrome, no_err, dbit_vld, dbit_idx, cbit_vld, cbit_idx,
            uncorrectable, corr_hi, corr_lo, corr_chk, 1'b0};
    in_hi = 32'hFFFF_0000; in_lo = 32'h0000_FFFF; in_chk = 8'hC3;
    repeat (2) @(negedge clk);
    check("R7 hold out_valid", 96'(out_valid), 96'd0);
    check("R7 hold values",
          {syndrome, no_err, dbit_vld, dbit_idx, cbit_vld, cbit_idx,
           uncorrectable, corr_hi, corr_lo, corr_chk, 1'b0}, held);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule